// File: doc/BRIEF.md
# Cache Access Issue and Retry Controller

This controller sits between a pipeline's memory stage and a cache port. It takes one memory access at a time, works out which cache command it needs, and sends that command. It also tracks whether the cache took the request. If the cache did not, it holds the request until a retry strobe arrives. It then waits for the response carrying the same tag and reports completion back to the pipeline as a single-cycle pulse.

**Command selection**
- A read becomes a plain read or a load-locked read.
- A write becomes a plain write, a store-conditional or a swap.

**Reservation monitor**
- A single-entry monitor holds the address reserved by the last completed load-locked.
- A store-conditional only goes out if the monitor holds a matching address.
- A store-conditional that fails completes at once with a failure flag and makes no cache request.

**Squash handling**
- The pipeline can squash an access by tag while it is outstanding.
- The response of a squashed access is dropped and no completion pulse is produced.

**Handshakes**
- The access input is valid/ready. `acc_ready` is high only when no access is outstanding, and an access is taken on a cycle with both `acc_valid` and `acc_ready` high.
- The request output is valid/ready. In the cycle an access is taken, the command goes out on `req_*` in that same cycle. A low `req_ready` in a cycle where `req_valid` is high counts as a rejection.
- After a rejection, `req_valid` stays low and the request is held unchanged. It is only offered again in a cycle where `retry_strobe` is high.
- Responses and completions carry no back-pressure.

Top module: `mem_issue_ctrl`

## Requirements
- R1: After reset, `ctl_state` is 0 (idle), `req_valid` and `done_valid` are low, and the reservation monitor is empty, so a store-conditional fails.
- R2: Command codes on `req_cmd` are read=0, write=1, load-locked=2, store-conditional=3, swap=4. A read is sent as 2 when `acc_locked` is set and as 0 otherwise, and no other value is ever sent.
- R3: A write is sent as 4 when `acc_swap` is set, whatever `acc_locked` is. Otherwise it is sent as 3 when `acc_locked` is set, and as 1 when neither flag is set.
- R4: `ctl_state` takes only the values 0 (idle), 1 (wait-retry) and 2 (wait-response). `acc_ready` is high only in state 0. An access offered in another state produces no request and does not disturb the held request.
- R5: A store-conditional whose address does not match the monitor produces no request. One cycle later it completes with `done_valid`=1, `done_sc_fail`=1 and `done_data`=0, and the state stays 0.
- R6: When a send is rejected, the state moves to 1. In that state `req_valid` stays low until `retry_strobe` is high, and the held command, address, data and tag do not change.
- R7: In state 1, a retry that is accepted moves the state to 2, and a retry that is rejected leaves the state at 1.
- R8: An accepted send moves the state to 2.
- R9: In state 2, a response whose tag matches returns the state to 0. If the access was not squashed, one cycle after that response `done_valid` is high for exactly one cycle with the access tag and the response data. A response with another tag is ignored.
- R10: If `squash_mask` has the bit for the access tag set in any cycle from acceptance up to the response, the response is dropped with no completion, and the state still returns to 0.
- R11: A completed load-locked that was not squashed reserves its address. A store-conditional to that address is sent as command 3. Any store-conditional, whether it passes or fails, empties the monitor, and a store-conditional to another address fails.
- R12: `lock_clear` empties the monitor. If it coincides with a load-locked completion, the new reservation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Controller idle and able to take an access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_locked | input | 1 | Load-locked / store-conditional flag |
| acc_swap | input | 1 | Swap flag, applies to writes |
| acc_tag | input | TW | Access tag |
| acc_addr | input | AW | Access address |
| acc_wdata | input | DW | Write data |
| req_valid | output | 1 | Request to cache |
| req_ready | input | 1 | Cache accepts request this cycle |
| req_cmd | output | 3 | Cache command code |
| req_addr | output | AW | Request address |
| req_wdata | output | DW | Request write data |
| req_tag | output | TW | Request tag |
| retry_strobe | input | 1 | Cache invites the held request again |
| rsp_valid | input | 1 | Cache response present |
| rsp_tag | input | TW | Response tag |
| rsp_data | input | DW | Response data |
| squash_mask | input | 2**TW | One squash bit per tag |
| lock_clear | input | 1 | External reservation loss |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | TW | Tag of completed access |
| done_data | output | DW | Response data of completed access |
| done_sc_fail | output | 1 | Completion is a failed store-conditional |
| ctl_state | output | 2 | Controller state |

## Verification
The bench targets the following corner cases:
- **Chains of rejections.** Sends are rejected up to three times in a row. A design that re-sent without a strobe, or dropped the held request, would show `req_valid` early or a wrong tag on the retry.
- **Stale squash.** A squash pulse is given one cycle ahead of the response and then removed. A design that only looked at the mask on the response cycle would produce a completion for a dead access.
- **Reservation rules.** A squashed load-locked, `lock_clear`, an address mismatch and a store-conditional repeated after a success must all fail the store-conditional, while `lock_clear` arriving together with a load-locked completion must not. A monitor with the wrong priority or no consume step would let a store through or block it.
- **Busy and stray responses.** The bench offers accesses while busy and sends responses with the wrong tag. A controller that overwrote its held request or ended early on those would be caught.

// File: rtl/mic_pkg.sv
package mic_pkg;
  typedef enum logic [2:0] {
    CMD_READ   = 3'd0,
    CMD_WRITE  = 3'd1,
    CMD_LDLOCK = 3'd2,
    CMD_STCOND = 3'd3,
    CMD_SWAP   = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WAIT_RETRY = 2'd1,
    ST_WAIT_RESP  = 2'd2
  } state_e;
endpackage

// File: rtl/mic_cmd_map.sv
module mic_cmd_map
  import mic_pkg::*;
(
  input  logic is_write,
  input  logic locked,
  input  logic swap,
  output cmd_e cmd
);
  always_comb begin
    if (!is_write)   cmd = locked ? CMD_LDLOCK : CMD_READ;
    else if (swap)   cmd = CMD_SWAP;
    else if (locked) cmd = CMD_STCOND;
    else             cmd = CMD_WRITE;
  end
endmodule

// File: rtl/mic_lock_mon.sv
module mic_lock_mon #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic          clr_ext,
  input  logic          consume,
  input  logic [AW-1:0] chk_addr,
  output logic          hit
);
  logic          vld_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (set_en) begin
      // a fresh reservation outranks any clear in the same cycle
      vld_q  <= 1'b1;
      addr_q <= set_addr;
    end else if (clr_ext || consume) begin
      vld_q  <= 1'b0;
    end
  end

  assign hit = vld_q && (addr_q == chk_addr);
endmodule

// File: rtl/mic_done_reg.sv
module mic_done_reg #(
  parameter int TW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          sc_fail_in,
  input  logic [TW-1:0] tag_in,
  input  logic [DW-1:0] data_in,
  output logic          done_valid,
  output logic          done_sc_fail,
  output logic [TW-1:0] done_tag,
  output logic [DW-1:0] done_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid   <= 1'b0;
      done_sc_fail <= 1'b0;
      done_tag     <= '0;
      done_data    <= '0;
    end else begin
      done_valid   <= fire;
      done_sc_fail <= fire && sc_fail_in;
      if (fire) begin
        done_tag  <= tag_in;
        done_data <= data_in;
      end
    end
  end
endmodule

// File: rtl/mem_issue_ctrl.sv
module mem_issue_ctrl
  import mic_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 3,
  localparam int NTAG = 1 << TW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  output logic            acc_ready,
  input  logic            acc_write,
  input  logic            acc_locked,
  input  logic            acc_swap,
  input  logic [TW-1:0]   acc_tag,
  input  logic [AW-1:0]   acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [2:0]      req_cmd,
  output logic [AW-1:0]   req_addr,
  output logic [DW-1:0]   req_wdata,
  output logic [TW-1:0]   req_tag,
  input  logic            retry_strobe,
  input  logic            rsp_valid,
  input  logic [TW-1:0]   rsp_tag,
  input  logic [DW-1:0]   rsp_data,
  input  logic [NTAG-1:0] squash_mask,
  input  logic            lock_clear,
  output logic            done_valid,
  output logic [TW-1:0]   done_tag,
  output logic [DW-1:0]   done_data,
  output logic            done_sc_fail,
  output logic [1:0]      ctl_state
);
  state_e        st_q, st_d;
  cmd_e          new_cmd;
  cmd_e          sv_cmd;
  logic [AW-1:0] sv_addr;
  logic [DW-1:0] sv_wdata;
  logic [TW-1:0] sv_tag;
  logic          sq_q;
  logic          lk_hit;

  logic acc_fire, sc_try, sc_fail, issue_new, send_ok;
  logic rsp_hit, squashed, done_fire, ll_done;

  mic_cmd_map u_map (
    .is_write (acc_write),
    .locked   (acc_locked),
    .swap     (acc_swap),
    .cmd      (new_cmd)
  );

  assign acc_ready = (st_q == ST_IDLE);
  assign acc_fire  = acc_valid && acc_ready;
  assign sc_try    = acc_fire && (new_cmd == CMD_STCOND);
  assign sc_fail   = sc_try && !lk_hit;
  assign issue_new = acc_fire && !sc_fail;

  // request port: new access straight through when idle, held copy otherwise
  assign req_valid = issue_new || ((st_q == ST_WAIT_RETRY) && retry_strobe);
  assign req_cmd   = (st_q == ST_IDLE) ? new_cmd   : sv_cmd;
  assign req_addr  = (st_q == ST_IDLE) ? acc_addr  : sv_addr;
  assign req_wdata = (st_q == ST_IDLE) ? acc_wdata : sv_wdata;
  assign req_tag   = (st_q == ST_IDLE) ? acc_tag   : sv_tag;
  assign send_ok   = req_valid && req_ready;

  assign rsp_hit   = (st_q == ST_WAIT_RESP) && rsp_valid && (rsp_tag == sv_tag);
  assign squashed  = sq_q || squash_mask[sv_tag];
  assign done_fire = sc_fail || (rsp_hit && !squashed);
  assign ll_done   = rsp_hit && !squashed && (sv_cmd == CMD_LDLOCK);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:       if (issue_new) st_d = send_ok ? ST_WAIT_RESP : ST_WAIT_RETRY;
      ST_WAIT_RETRY: if (send_ok)   st_d = ST_WAIT_RESP;
      ST_WAIT_RESP:  if (rsp_hit)   st_d = ST_IDLE;
      default:                      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sv_cmd   <= CMD_READ;
      sv_addr  <= '0;
      sv_wdata <= '0;
      sv_tag   <= '0;
      sq_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (issue_new) begin
        sv_cmd   <= new_cmd;
        sv_addr  <= acc_addr;
        sv_wdata <= acc_wdata;
        sv_tag   <= acc_tag;
        sq_q     <= squash_mask[acc_tag];
      end else if (st_q != ST_IDLE) begin
        sq_q     <= squashed;
      end
    end
  end

  mic_lock_mon #(.AW(AW)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (ll_done),
    .set_addr (sv_addr),
    .clr_ext  (lock_clear),
    .consume  (sc_try),
    .chk_addr (acc_addr),
    .hit      (lk_hit)
  );

  mic_done_reg #(.TW(TW), .DW(DW)) u_done (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (done_fire),
    .sc_fail_in   (sc_fail),
    .tag_in       (sc_fail ? acc_tag : sv_tag),
    .data_in      (sc_fail ? '0 : rsp_data),
    .done_valid   (done_valid),
    .done_sc_fail (done_sc_fail),
    .done_tag     (done_tag),
    .done_data    (done_data)
  );

  assign ctl_state = st_q;
endmodule

// File: rtl/mem_issue_ctrl_chk.sv
module mem_issue_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 3,
  localparam int NTAG = 1 << TW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_ready,
  input logic            acc_write,
  input logic            acc_locked,
  input logic            acc_swap,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_cmd,
  input logic [AW-1:0]   req_addr,
  input logic [TW-1:0]   req_tag,
  input logic            retry_strobe,
  input logic            rsp_valid,
  input logic [TW-1:0]   rsp_tag,
  input logic [NTAG-1:0] squash_mask,
  input logic            done_valid,
  input logic            done_sc_fail,
  input logic [1:0]      ctl_state
);
  assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_cmd <= 3'd4));

  assert_state_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_state != 2'd3);

  assert_resp_wait_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd2) |-> !req_valid);

  assert_sc_fail_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_write && acc_locked && !acc_swap && !req_valid)
    |=> (done_valid && done_sc_fail));

  assert_reject_to_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd0 && req_valid && !req_ready) |=> (ctl_state == 2'd1));

  assert_retry_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd1 && !retry_strobe) |-> !req_valid);

  assert_retry_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd1 && $past(ctl_state) == 2'd1)
    |-> ($stable(req_tag) && $stable(req_cmd) && $stable(req_addr)));

  assert_retry_reject_stay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd1 && retry_strobe && !req_ready) |=> (ctl_state == 2'd1));

  assert_accept_to_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ctl_state == 2'd2));

  assert_done_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ($past(rsp_valid) || $past(acc_valid && acc_ready)));

  assert_squash_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd2 && rsp_valid && rsp_tag == req_tag && squash_mask[req_tag])
    |=> !done_valid);
endmodule

bind mem_issue_ctrl mem_issue_ctrl_chk #(.AW(AW), .DW(DW), .TW(TW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_ready    (acc_ready),
  .acc_write    (acc_write),
  .acc_locked   (acc_locked),
  .acc_swap     (acc_swap),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_cmd      (req_cmd),
  .req_addr     (req_addr),
  .req_tag      (req_tag),
  .retry_strobe (retry_strobe),
  .rsp_valid    (rsp_valid),
  .rsp_tag      (rsp_tag),
  .squash_mask  (squash_mask),
  .done_valid   (done_valid),
  .done_sc_fail (done_sc_fail),
  .ctl_state    (ctl_state)
);

// File: tb/mem_issue_ctrl_test.sv
module mem_issue_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_locked = 1'b0, acc_swap = 1'b0;
  logic [2:0]  acc_tag = '0;
  logic [15:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        acc_ready;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [2:0]  req_cmd;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic [2:0]  req_tag;
  logic        retry_strobe = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [2:0]  rsp_tag = '0;
  logic [31:0] rsp_data = '0;
  logic [7:0]  squash_mask = '0;
  logic        lock_clear = 1'b0;
  logic        done_valid;
  logic [2:0]  done_tag;
  logic [31:0] done_data;
  logic        done_sc_fail;
  logic [1:0]  ctl_state;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  mem_issue_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_locked(acc_locked), .acc_swap(acc_swap), .acc_tag(acc_tag),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .retry_strobe(retry_strobe),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .squash_mask(squash_mask), .lock_clear(lock_clear),
    .done_valid(done_valid), .done_tag(done_tag), .done_data(done_data),
    .done_sc_fail(done_sc_fail), .ctl_state(ctl_state)
  );

  typedef struct packed {
    logic        wr;
    logic        lk;
    logic        sw;
    logic [2:0]  tag;
    logic [15:0] addr;
    logic [1:0]  nrej;
    logic        sq;
    logic [31:0] data;
    logic [2:0]  cmd;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{1'b0, 1'b0, 1'b0, 3'd1, 16'h0100, 2'd0, 1'b0, 32'h1111_2222, 3'd0},
    '{1'b1, 1'b0, 1'b0, 3'd2, 16'h0104, 2'd1, 1'b0, 32'h0000_0000, 3'd1},
    '{1'b0, 1'b1, 1'b0, 3'd3, 16'h0200, 2'd0, 1'b0, 32'hAAAA_0001, 3'd2},
    '{1'b1, 1'b1, 1'b0, 3'd4, 16'h0200, 2'd2, 1'b0, 32'h0000_0001, 3'd3},
    '{1'b1, 1'b0, 1'b1, 3'd5, 16'h0300, 2'd0, 1'b0, 32'hBEEF_0005, 3'd4},
    '{1'b1, 1'b1, 1'b1, 3'd6, 16'h0300, 2'd1, 1'b0, 32'hBEEF_0006, 3'd4},
    '{1'b0, 1'b0, 1'b0, 3'd7, 16'h0400, 2'd0, 1'b1, 32'h7777_7777, 3'd0},
    '{1'b0, 1'b1, 1'b0, 3'd0, 16'h0500, 2'd3, 1'b1, 32'h5555_5555, 3'd2}
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic run_vec(input logic wr, input logic lk, input logic sw,
                         input logic [2:0] tag, input logic [15:0] addr,
                         input int nrej, input logic sq, input logic [31:0] data,
                         input logic [2:0] ecmd, input logic clr);
    string rq;
    rq = wr ? "R3" : "R2";
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_locked = lk; acc_swap = sw;
    acc_tag = tag; acc_addr = addr; acc_wdata = {16'h5A5A, addr};
    req_ready = (nrej == 0);
    #1;
    check("R4", acc_ready, 1);
    check(rq, req_valid, 1);
    check(rq, req_cmd, ecmd);
    @(negedge clk);
    acc_valid = 1'b0; req_ready = 1'b0;
    if (nrej == 0) check("R8", ctl_state, 2);
    else           check("R6", ctl_state, 1);
    for (int k = 1; k <= nrej; k++) begin
      #1 check("R6", req_valid, 0);
      @(negedge clk);
      retry_strobe = 1'b1; req_ready = (k == nrej);
      #1;
      check("R6", req_valid, 1);
      check("R6", req_tag, tag);
      check("R6", req_addr, addr);
      @(negedge clk);
      retry_strobe = 1'b0; req_ready = 1'b0;
      check("R7", ctl_state, (k == nrej) ? 2 : 1);
    end
    if (sq) squash_mask[tag] = 1'b1;
    @(negedge clk);
    squash_mask = '0;
    rsp_valid = 1'b1; rsp_tag = tag; rsp_data = data; lock_clear = clr;
    @(negedge clk);
    rsp_valid = 1'b0; lock_clear = 1'b0;
    check("R9", ctl_state, 0);
    if (sq) check("R10", done_valid, 0);
    else begin
      check("R9", done_valid, 1);
      check("R9", done_tag, tag);
      check("R9", done_data, data);
      check("R9", done_sc_fail, 0);
    end
    @(negedge clk);
    check("R9", done_valid, 0);
  endtask

  task automatic sc_expect_fail(input string rq, input logic [2:0] tag, input logic [15:0] addr);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_locked = 1'b1; acc_swap = 1'b0;
    acc_tag = tag; acc_addr = addr; req_ready = 1'b1;
    #1 check(rq, req_valid, 0);
    @(negedge clk);
    acc_valid = 1'b0; req_ready = 1'b0;
    check("R5", done_valid, 1);
    check("R5", done_sc_fail, 1);
    check("R5", done_tag, tag);
    check("R5", done_data, 0);
    check("R5", ctl_state, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", ctl_state, 0);
    check("R1", req_valid, 0);
    check("R1", done_valid, 0);
    check("R1", acc_ready, 1);
    // R1: empty monitor after reset
    sc_expect_fail("R1", 3'd2, 16'h0000);

    foreach (VT[i])
      run_vec(VT[i].wr, VT[i].lk, VT[i].sw, VT[i].tag, VT[i].addr,
              int'(VT[i].nrej), VT[i].sq, VT[i].data, VT[i].cmd, 1'b0);

    // R11: squashed load-locked set no reservation
    sc_expect_fail("R11", 3'd1, 16'h0500);
    // R11: store-conditional after a successful one fails (consumed)
    sc_expect_fail("R11", 3'd3, 16'h0200);

    // R12: lock_clear empties the monitor
    run_vec(1'b0, 1'b1, 1'b0, 3'd2, 16'h0600, 0, 1'b0, 32'h6666_0000, 3'd2, 1'b0);
    @(negedge clk); lock_clear = 1'b1;
    @(negedge clk); lock_clear = 1'b0;
    sc_expect_fail("R12", 3'd2, 16'h0600);

    // R12: clear coinciding with load-locked completion loses
    run_vec(1'b0, 1'b1, 1'b0, 3'd3, 16'h0700, 0, 1'b0, 32'h7000_0007, 3'd2, 1'b1);
    run_vec(1'b1, 1'b1, 1'b0, 3'd4, 16'h0700, 0, 1'b0, 32'h0000_0001, 3'd3, 1'b0);

    // R11: address mismatch fails
    run_vec(1'b0, 1'b1, 1'b0, 3'd5, 16'h0800, 0, 1'b0, 32'h8000_0008, 3'd2, 1'b0);
    sc_expect_fail("R11", 3'd5, 16'h0804);

    // R4: busy refusal, R9: stray tag ignored
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_locked = 1'b0; acc_swap = 1'b0;
    acc_tag = 3'd1; acc_addr = 16'h0900; req_ready = 1'b0;
    @(negedge clk);
    acc_tag = 3'd2; acc_addr = 16'h0A00; req_ready = 1'b1;
    #1;
    check("R4", ctl_state, 1);
    check("R4", acc_ready, 0);
    check("R4", req_valid, 0);
    @(negedge clk);
    acc_valid = 1'b0; retry_strobe = 1'b1;
    #1;
    check("R4", req_tag, 1);
    check("R4", req_addr, 16'h0900);
    @(negedge clk);
    retry_strobe = 1'b0; req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_tag = 3'd3; rsp_data = 32'hDEAD_0003;
    @(negedge clk);
    check("R9", ctl_state, 2);
    check("R9", done_valid, 0);
    rsp_tag = 3'd1; rsp_data = 32'h0900_0001;
    @(negedge clk);
    rsp_valid = 1'b0;
    check("R9", done_valid, 1);
    check("R9", done_tag, 1);
    check("R9", done_data, 32'h0900_0001);
    check("R9", ctl_state, 0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule